// File: doc/BRIEF.md
# Single-Line Interrupt Entry Sequencer

This block decides when a 16-bit processor accepts an interrupt. It owns the interrupt-enable flag and reacts to four commands from the instruction decoder: enable, disable, I/O reset and acknowledge. Enabling is deferred. The command only primes the flag, and interrupts become live once the instruction that follows the enable has finished. Devices present their requests as a vector ordered by bus position. The OR of that vector forms the single shared request line.

At every instruction boundary the processor holds `bnd_valid` high together with the address of the next instruction. The boundary ends with a one-cycle `bnd_done`. If the flag is live and any device is requesting, the sequencer clears the flag and writes the return address to physical location 0. It then reads location 1 and follows the pointer chain until it reaches a word whose top bit is clear. It reports the low 15 bits of that word as the redirect target. In every other case the boundary completes with no redirect and no memory traffic.

An acknowledge command returns, one cycle later, the 6-bit address of the requesting device that sits nearest the processor.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, and one cycle after an I/O reset command (cmd_op 3), `int_on` is 0 and no pending enable remains.
- R2: After an enable command (cmd_op 1), `int_on` stays 0 until the first boundary that follows is accepted. That boundary never starts an entry. `int_on` is 1 from the cycle after it.
- R3: Requests are looked at only while a boundary is being accepted. With `bnd_valid` low, the sequencer never starts a memory access.
- R4: An entry clears `int_on` and first writes `{1'b0, next_pc}` to address 0 (mem_we 1).
- R5: After the save, the sequencer reads address 1. Each word read with bit 15 set sends the next read to that word's bits 14:0. The first word read with bit 15 clear ends the chain. `bnd_done` then pulses with `redirect` 1 and `target_pc` equal to that word's bits 14:0.
- R6: A boundary that takes no interrupt ends with `bnd_done` high and `redirect` 0, and it makes no memory access.
- R7: A disable command (cmd_op 2) clears both `int_on` and any pending enable at once.
- R8: One cycle after an acknowledge command (cmd_op 4), `ack_valid` is 1. `ack_addr` is then the lowest index whose `dev_req` bit is set, where index 0 is nearest the processor. It is 0 if no bit is set.
- R9: A boundary with `int_on` 1 and no request takes no interrupt and leaves `int_on` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | 0 none, 1 enable, 2 disable, 3 I/O reset, 4 acknowledge |
| dev_req | input | 64 | Device requests, bit index equals bus position |
| bnd_valid | input | 1 | Instruction boundary, held until bnd_done |
| next_pc | input | 15 | Address of the next instruction |
| bnd_done | output | 1 | Boundary handled, one cycle |
| redirect | output | 1 | Execution continues at target_pc |
| target_pc | output | 15 | Handler address |
| int_on | output | 1 | Interrupts are live |
| ack_valid | output | 1 | Acknowledge answer is valid |
| ack_addr | output | 6 | Address of the winning device |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 15 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access complete |

## Verification
The bench targets the one-instruction enable delay. A design that went live at once would redirect on the very first boundary after the enable. It also checks that disable cancels a primed enable; a design that kept it would take an interrupt two boundaries later. Pointer chains of depth one and three probe the indirection rule: stopping early or late yields a wrong target or an extra read. Acknowledge vectors with scattered, single-top and all-ones requests, plus the empty case, expose an encoder that picks the highest set bit or leaves a stale address.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
   typedef enum logic [2:0] {
      CMD_NONE = 3'd0,
      CMD_EN   = 3'd1,
      CMD_DIS  = 3'd2,
      CMD_IORST= 3'd3,
      CMD_ACK  = 3'd4
   } cmd_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SAVE  = 2'd1,
      ST_CHAIN = 2'd2,
      ST_DONE  = 2'd3
   } seq_state_e;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int NDEV       = 64,
   parameter bit NEAR_IS_LOW = 1'b1,
   localparam int IDX_W     = $clog2(NDEV)
) (
   input  logic [NDEV-1:0]  req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   assign any = |req;

   generate
      if (NEAR_IS_LOW) begin : g_low_first
         always_comb begin
            idx = '0;
            for (int i = NDEV-1; i >= 0; i--) begin
               if (req[i]) idx = IDX_W'(i);
            end
         end
      end else begin : g_high_first
         always_comb begin
            idx = '0;
            for (int i = 0; i < NDEV; i++) begin
               if (req[i]) idx = IDX_W'(i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl
   import irq_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [2:0] cmd_op,
   input  logic       bnd_accept,
   input  logic       take,
   output logic       live,
   output logic       primed
);
   logic live_n, primed_n;
   logic kill;

   assign kill = cmd_valid && (cmd_op == CMD_DIS || cmd_op == CMD_IORST);

   always_comb begin
      live_n   = live;
      primed_n = primed;
      if (take) begin
         live_n = 1'b0;
      end else if (bnd_accept && primed) begin
         live_n = 1'b1;
      end
      if (bnd_accept) primed_n = 1'b0;
      if (cmd_valid && cmd_op == CMD_EN && !live_n) primed_n = 1'b1;
      if (kill) begin
         live_n   = 1'b0;
         primed_n = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live   <= 1'b0;
         primed <= 1'b0;
      end else begin
         live   <= live_n;
         primed <= primed_n;
      end
   end
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
   import irq_seq_pkg::*;
#(
   parameter int PC_W   = 15,
   parameter int DATA_W = 16,
   parameter int SAVE_LOC = 0,
   parameter int VEC_LOC  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bnd_valid,
   input  logic [PC_W-1:0]   next_pc,
   input  logic              live,
   input  logic              any_req,
   output logic              bnd_accept,
   output logic              take,
   output logic              bnd_done,
   output logic              redirect,
   output logic [PC_W-1:0]   target_pc,
   output logic              mem_req,
   output logic              mem_we,
   output logic [PC_W-1:0]   mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack
);
   localparam int IND_BIT = DATA_W - 1;

   seq_state_e        state;
   logic [PC_W-1:0]   ret_pc;
   logic [PC_W-1:0]   ptr;
   logic              redir_q;
   logic [PC_W-1:0]   tgt_q;

   assign bnd_accept = (state == ST_IDLE) && bnd_valid;
   assign take       = bnd_accept && live && any_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         ret_pc  <= '0;
         ptr     <= '0;
         redir_q <= 1'b0;
         tgt_q   <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (take) begin
                  ret_pc  <= next_pc;
                  state   <= ST_SAVE;
               end else if (bnd_accept) begin
                  redir_q <= 1'b0;
                  state   <= ST_DONE;
               end
            end
            ST_SAVE: begin
               if (mem_ack) begin
                  ptr   <= PC_W'(VEC_LOC);
                  state <= ST_CHAIN;
               end
            end
            ST_CHAIN: begin
               if (mem_ack) begin
                  if (mem_rdata[IND_BIT]) begin
                     ptr <= mem_rdata[PC_W-1:0];
                  end else begin
                     tgt_q   <= mem_rdata[PC_W-1:0];
                     redir_q <= 1'b1;
                     state   <= ST_DONE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      case (state)
         ST_SAVE: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = PC_W'(SAVE_LOC);
            mem_wdata = DATA_W'(ret_pc);
         end
         ST_CHAIN: begin
            mem_req  = 1'b1;
            mem_addr = ptr;
         end
         default: ;
      endcase
   end

   assign bnd_done  = (state == ST_DONE);
   assign redirect  = bnd_done && redir_q;
   assign target_pc = tgt_q;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_seq_pkg::*;
#(
   parameter int NDEV   = 64,
   parameter int PC_W   = 15,
   parameter int DATA_W = 16,
   localparam int DEV_W = $clog2(NDEV)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [NDEV-1:0]   dev_req,
   input  logic              bnd_valid,
   input  logic [PC_W-1:0]   next_pc,
   output logic              bnd_done,
   output logic              redirect,
   output logic [PC_W-1:0]   target_pc,
   output logic              int_on,
   output logic              ack_valid,
   output logic [DEV_W-1:0]  ack_addr,
   output logic              mem_req,
   output logic              mem_we,
   output logic [PC_W-1:0]   mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack
);
   if (DATA_W != PC_W + 1) begin : g_bad_width
      $error("DATA_W must be PC_W plus one indirection bit");
   end
   if (NDEV < 2) begin : g_bad_ndev
      $error("NDEV must be at least 2");
   end

   logic             any_req;
   logic [DEV_W-1:0] win_idx;
   logic             bnd_accept, take, live, primed;

   irq_prio_enc #(.NDEV(NDEV), .NEAR_IS_LOW(1'b1)) u_enc (
      .req (dev_req),
      .any (any_req),
      .idx (win_idx)
   );

   irq_enable_ctl u_en (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_op     (cmd_op),
      .bnd_accept (bnd_accept),
      .take       (take),
      .live       (live),
      .primed     (primed)
   );

   irq_entry_fsm #(.PC_W(PC_W), .DATA_W(DATA_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .bnd_valid  (bnd_valid),
      .next_pc    (next_pc),
      .live       (live),
      .any_req    (any_req),
      .bnd_accept (bnd_accept),
      .take       (take),
      .bnd_done   (bnd_done),
      .redirect   (redirect),
      .target_pc  (target_pc),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata),
      .mem_ack    (mem_ack)
   );

   assign int_on = live;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_valid <= 1'b0;
         ack_addr  <= '0;
      end else begin
         ack_valid <= cmd_valid && (cmd_op == CMD_ACK);
         if (cmd_valid && cmd_op == CMD_ACK) ack_addr <= win_idx;
      end
   end
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk
   import irq_seq_pkg::*;
#(
   parameter int NDEV   = 64,
   parameter int PC_W   = 15,
   parameter int DATA_W = 16,
   localparam int DEV_W = $clog2(NDEV)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [2:0]        cmd_op,
   input logic [NDEV-1:0]   dev_req,
   input logic              bnd_valid,
   input logic              int_on,
   input logic              ack_valid,
   input logic [DEV_W-1:0]  ack_addr,
   input logic              mem_req,
   input logic              mem_we,
   input logic [PC_W-1:0]   mem_addr,
   input logic [DATA_W-1:0] mem_wdata
);
   logic [NDEV-1:0] req_q;
   logic [NDEV-1:0] below;

   always_ff @(posedge clk) req_q <= dev_req;
   assign below = (NDEV'(1) << ack_addr) - NDEV'(1);

   a_r1_iorst_off: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == CMD_IORST |=> !int_on);
   a_r7_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == CMD_DIS |=> !int_on);
   a_r2_enable_deferred: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == CMD_EN && !int_on |=> !int_on);
   a_r3_no_access_without_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      !bnd_valid && !mem_req |=> !mem_req);
   a_r4_save_location: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_addr == '0 && !mem_wdata[DATA_W-1]);
   a_r4_entry_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req && mem_we) |-> !int_on);
   a_r8_ack_winner: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid && req_q != '0 |-> req_q[ack_addr] && (req_q & below) == '0);
   a_r8_ack_empty: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid && req_q == '0 |-> ack_addr == '0);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.NDEV(NDEV), .PC_W(PC_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .dev_req   (dev_req),
   .bnd_valid (bnd_valid),
   .int_on    (int_on),
   .ack_valid (ack_valid),
   .ack_addr  (ack_addr),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata)
);

// File: tb/irq_entry_seq_test.sv
`timescale 1ns/1ps
module irq_entry_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = 3'd0;
   logic [63:0] dev_req = '0;
   logic        bnd_valid = 1'b0;
   logic [14:0] next_pc = '0;
   logic        bnd_done, redirect, int_on, ack_valid;
   logic [14:0] target_pc, mem_addr;
   logic [5:0]  ack_addr;
   logic        mem_req, mem_we;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;

   int n_chk = 0, n_fail = 0;
   int n_acc = 0;
   logic [15:0] mem [0:255];

   always #2 clk = ~clk;

   irq_entry_seq uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .dev_req(dev_req), .bnd_valid(bnd_valid), .next_pc(next_pc),
      .bnd_done(bnd_done), .redirect(redirect), .target_pc(target_pc),
      .int_on(int_on), .ack_valid(ack_valid), .ack_addr(ack_addr),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   always @(negedge clk) begin
      if (mem_req && !mem_ack) begin
         mem_ack = 1'b1;
         n_acc++;
         if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
         else mem_rdata = mem[mem_addr[7:0]];
      end else begin
         mem_ack = 1'b0;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cmd(input logic [2:0] op);
      @(negedge clk);
      cmd_op = op; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 3'd0;
   endtask

   task automatic boundary(input logic [14:0] pc, output logic redir, output logic [14:0] tgt);
      int guard = 0;
      @(negedge clk);
      next_pc = pc; bnd_valid = 1'b1;
      do begin
         @(negedge clk);
         guard++;
      end while (!bnd_done && guard < 200);
      redir = redirect; tgt = target_pc;
      bnd_valid = 1'b0;
      if (guard >= 200) check("boundary hang", 32'd1, 32'd0);
   endtask

   localparam logic [63:0] REQ_T [8] = '{
      64'h0, 64'h1, 64'h8000_0000_0000_0000, 64'h100,
      64'hF0, 64'h8000_0000_0000_0002, 64'h0000_0001_0000_0000, '1};
   localparam logic [5:0] EXP_T [8] = '{6'd0, 6'd0, 6'd63, 6'd8, 6'd4, 6'd1, 6'd32, 6'd0};

   initial begin
      #100000;
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic r; logic [14:0] t; int a0;
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset int_on", int_on, 0);
      check("R1 reset ack_valid", ack_valid, 0);

      // R8 acknowledge vectors
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         dev_req = REQ_T[k]; cmd_op = 3'd4; cmd_valid = 1'b1;
         @(negedge clk);
         check("R8 ack_valid", ack_valid, 1);
         check("R8 ack_addr", ack_addr, EXP_T[k]);
         cmd_valid = 1'b0; cmd_op = 3'd0;
      end

      // R6 boundary while off, request present: no entry
      dev_req = 64'h10; a0 = n_acc;
      boundary(15'h0100, r, t);
      check("R6 no redirect when off", r, 0);
      check("R6 no memory access", n_acc - a0, 0);

      // R3 requests without a boundary cause nothing
      cmd(3'd1);
      boundary(15'h0101, r, t);
      check("R2 first boundary after enable no entry", r, 0);
      @(negedge clk);
      check("R2 live after first boundary", int_on, 1);
      a0 = n_acc;
      repeat (10) @(negedge clk);
      check("R3 no access between boundaries", n_acc - a0, 0);

      // R4/R5 entry with three-level chain
      mem[1] = 16'h8005; mem[5] = 16'h8020; mem[32] = 16'h0123;
      boundary(15'h1ABC, r, t);
      check("R5 redirect", r, 1);
      check("R5 chain target", t, 15'h0123);
      check("R4 return pc saved", mem[0], 16'h1ABC);
      check("R4 int_on cleared", int_on, 0);
      check("R5 access count", n_acc - a0, 4);

      // R2 enable: immediate boundary does not enter; next does, direct vector
      mem[1] = 16'h0456;
      cmd(3'd1);
      check("R2 not live right after enable", int_on, 0);
      boundary(15'h0200, r, t);
      check("R2 delay boundary", r, 0);
      boundary(15'h0201, r, t);
      check("R5 direct vector redirect", r, 1);
      check("R5 direct vector target", t, 15'h0456);
      check("R4 second save", mem[0], 16'h0201);

      // R7 disable cancels primed enable
      cmd(3'd1);
      cmd(3'd2);
      boundary(15'h0300, r, t);
      boundary(15'h0301, r, t);
      check("R7 primed enable cancelled", r, 0);
      check("R7 int_on", int_on, 0);

      // R9 live, no request
      cmd(3'd1);
      dev_req = '0;
      boundary(15'h0400, r, t);
      boundary(15'h0401, r, t);
      check("R9 no entry without request", r, 0);
      @(negedge clk);
      check("R9 stays live", int_on, 1);

      // R7 disable when live
      cmd(3'd2);
      check("R7 disable clears live", int_on, 0);

      // R1 I/O reset when live and when primed
      cmd(3'd1);
      boundary(15'h0500, r, t);
      @(negedge clk);
      cmd(3'd3);
      check("R1 iorst clears live", int_on, 0);
      cmd(3'd1);
      cmd(3'd3);
      dev_req = 64'h4;
      boundary(15'h0600, r, t);
      boundary(15'h0601, r, t);
      check("R1 iorst cancels primed", r, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule